// File: doc/BRIEF.md
# Double-Buffered Dual Converter Code Register File

This block holds the digital codes for two 12-bit converter channels, A and B. A host with an 8-bit data bus loads each channel in two byte-wide pieces, a low byte and a high nibble, into a first rank of input registers. A separate update action then copies both channels' input registers into the second rank, the converter code registers, in the same clock cycle. Software can therefore prepare new codes for both channels one piece at a time and make them take effect together.

All host strobes (chip select, write, update) are active low and arrive asynchronously. They are sampled through a two-flop synchroniser in the block clock domain together with the address and data lines, and a write takes effect on the detected rising edge of the write strobe. Holding the update strobe and the write strobe low together makes the code registers track the input registers continuously. An active-low clear input empties every register at once, without waiting for a clock.

Top module: `dual_dac_loader`

## Requirements
- R1: A write to a low input register stores bus bits 7..0 as code bits 7..0; a write to a high input register stores bus bits 3..0 as code bits 11..8, and bus bits 7..4 have no effect.
- R2: A write commits on the synchronised rising edge of the write strobe, using the address and data sampled while the strobe was low, and only when chip select was low at that sample; the input register holds the value no later than three clock edges after the strobe rises.
- R3: The two address bits pick the target: 2'b00 channel A low, 2'b01 channel A high, 2'b10 channel B low, 2'b11 channel B high; only that one register changes.
- R4: While the synchronised update strobe and write strobe are both low, both 12-bit code registers are loaded from their channel's input registers in the same clock cycle.
- R5: While update and write are held low together, the code registers follow the input registers, including a write committing at the end of that window, whatever the state of chip select and the address.
- R6: A low clear input forces all four input registers and both code registers to zero at once, without a clock edge, and no write or update takes effect while it is low or in the two cycles after it rises.
- R7: With write high, or chip select high during a write pulse, and update high, no register changes.
- R8: Writing an input register does not change the code outputs until an update occurs.
- R9: After reset both code outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| bus_data | input | 8 | Host data bus |
| bus_addr | input | 2 | Target register select |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| upd_n | input | 1 | Active-low update strobe |
| clr_n | input | 1 | Active-low asynchronous clear |
| dac_a | output | 12 | Channel A code register |
| dac_b | output | 12 | Channel B code register |

## Verification
The hardest case to reach is a write that commits inside an update window: the update strobe must already be low through the synchroniser when the write strobe's rising edge is detected, so the new byte passes straight to the code output in the same cycle as it enters the input register. The bench holds update low across a complete write pulse and checks the code output before update is released. A second hard case is proving that a blocked write left the input registers untouched; the bench brings this out by issuing a normal update afterwards and checking that the code outputs keep their previous values.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
   // Register select encoding; the decoder depends on bit 1 = channel, bit 0 = part
   typedef enum logic [1:0] {
      SEL_A_LO = 2'b00,
      SEL_A_HI = 2'b01,
      SEL_B_LO = 2'b10,
      SEL_B_HI = 2'b11
   } reg_sel_e;

   localparam int unsigned NUM_CHANNELS = 2;
   localparam int unsigned PARTS_PER_CH = 2;
   localparam int unsigned NUM_INPUT_REGS = NUM_CHANNELS * PARTS_PER_CH;
   localparam int unsigned SEL_W = $clog2(NUM_INPUT_REGS);
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
   parameter int unsigned        WIDTH   = 1,
   parameter int unsigned        STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bus_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("bus_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/write_decode.sv
module write_decode
   import dac_loader_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      clr_int_n,
   input  logic                      wr_now_n,
   input  logic                      wr_prev_n,
   input  logic                      cs_prev_n,
   input  logic                      upd_prev_n,
   input  logic [SEL_W-1:0]          sel_prev,
   output logic [NUM_INPUT_REGS-1:0] wr_en,
   output logic                      xfer
);
   logic commit;
   reg_sel_e sel;

   // rising edge of write, chip select sampled alongside the low phase
   assign commit = wr_now_n && !wr_prev_n && !cs_prev_n;
   assign sel    = reg_sel_e'(sel_prev);

   always_comb begin
      wr_en = '0;
      if (commit) begin
         unique case (sel)
            SEL_A_LO: wr_en[0] = 1'b1;
            SEL_A_HI: wr_en[1] = 1'b1;
            SEL_B_LO: wr_en[2] = 1'b1;
            SEL_B_HI: wr_en[3] = 1'b1;
            default:  wr_en    = '0;
         endcase
      end
   end

   // update and write low together in the sampled phase
   assign xfer = !upd_prev_n && !wr_prev_n;

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!clr_int_n)
      $onehot0(wr_en)) else $error("more than one input register enabled"); // R3

   AST_CS_BLOCKS: assert property (@(posedge clk) disable iff (!clr_int_n)
      cs_prev_n |-> (wr_en == '0)) else $error("write enabled with chip select high"); // R7

   logic unused_data_w;
   assign unused_data_w = (DATA_W == 0);
endmodule

// File: rtl/channel_regs.sv
module channel_regs #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              clr_int_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              xfer,
   input  logic [DATA_W-1:0] data,
   output logic [CODE_W-1:0] code
);
   localparam int unsigned HI_W = CODE_W - DATA_W;

   if (CODE_W <= DATA_W || HI_W > DATA_W) begin : g_bad_split
      $error("channel_regs: CODE_W must lie in (DATA_W, 2*DATA_W]");
   end

   logic [DATA_W-1:0] in_lo_q, in_lo_d;
   logic [HI_W-1:0]   in_hi_q, in_hi_d;
   logic [CODE_W-1:0] code_q;

   always_comb begin
      in_lo_d = wr_lo ? data : in_lo_q;
      in_hi_d = wr_hi ? data[HI_W-1:0] : in_hi_q;
   end

   always_ff @(posedge clk or negedge clr_int_n) begin
      if (!clr_int_n) begin
         in_lo_q <= '0;
         in_hi_q <= '0;
      end else begin
         in_lo_q <= in_lo_d;
         in_hi_q <= in_hi_d;
      end
   end

   // second rank takes the next-state value so a write ending an update window passes through
   always_ff @(posedge clk or negedge clr_int_n) begin
      if (!clr_int_n)  code_q <= '0;
      else if (xfer)   code_q <= {in_hi_d, in_lo_d};
   end

   assign code = code_q;

   AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!clr_int_n)
      xfer |=> (code_q == {in_hi_q, in_lo_q})) else $error("code register missed transfer"); // R4

   AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!clr_int_n)
      !xfer |=> $stable(code_q)) else $error("code register moved without update"); // R8

   AST_INPUT_HOLDS: assert property (@(posedge clk) disable iff (!clr_int_n)
      (!wr_lo && !wr_hi) |=> ($stable(in_lo_q) && $stable(in_hi_q))) else $error("input register moved without write"); // R7

   AST_HI_LANDS: assert property (@(posedge clk) disable iff (!clr_int_n)
      wr_hi |=> (in_hi_q == $past(data[HI_W-1:0]))) else $error("high nibble not stored"); // R1
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
   import dac_loader_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CODE_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_data,
   input  logic [1:0]        bus_addr,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              upd_n,
   input  logic              clr_n,
   output logic [11:0]       dac_a,
   output logic [11:0]       dac_b
);
   localparam int unsigned BUNDLE_W = DATA_W + SEL_W + 3;

   if (DATA_W != 8 || CODE_W != 12) begin : g_bad_port_width
      $error("dual_dac_loader: port widths are fixed at 8-bit bus and 12-bit codes");
   end

   // clear: asserts at once, releases through the synchroniser
   logic arst_n, clr_int_n;
   assign arst_n = rst_n & clr_n;

   bus_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clr_sync (
      .clk   (clk),
      .rst_n (arst_n),
      .d     (1'b1),
      .q     (clr_int_n)
   );

   // bus and strobes travel together so address and data align with the write edge
   logic [BUNDLE_W-1:0] bundle_in, bundle_now, bundle_prev;
   assign bundle_in = {upd_n, cs_n, wr_n, bus_addr, bus_data};

   bus_sync #(.WIDTH(BUNDLE_W), .STAGES(SYNC_STAGES), .RST_VAL({3'b111, {(BUNDLE_W-3){1'b0}}})) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bundle_in),
      .q     (bundle_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bundle_prev <= {3'b111, {(BUNDLE_W-3){1'b0}}};
      else        bundle_prev <= bundle_now;
   end

   logic              wr_now_n, wr_prev_n, cs_prev_n, upd_prev_n;
   logic [SEL_W-1:0]  sel_prev;
   logic [DATA_W-1:0] data_prev;

   assign wr_now_n   = bundle_now[DATA_W+SEL_W];
   assign wr_prev_n  = bundle_prev[DATA_W+SEL_W];
   assign cs_prev_n  = bundle_prev[DATA_W+SEL_W+1];
   assign upd_prev_n = bundle_prev[DATA_W+SEL_W+2];
   assign sel_prev   = bundle_prev[DATA_W +: SEL_W];
   assign data_prev  = bundle_prev[DATA_W-1:0];

   logic [NUM_INPUT_REGS-1:0] wr_en;
   logic                      xfer;

   write_decode #(.DATA_W(DATA_W)) u_decode (
      .clk        (clk),
      .clr_int_n  (clr_int_n),
      .wr_now_n   (wr_now_n),
      .wr_prev_n  (wr_prev_n),
      .cs_prev_n  (cs_prev_n),
      .upd_prev_n (upd_prev_n),
      .sel_prev   (sel_prev),
      .wr_en      (wr_en),
      .xfer       (xfer)
   );

   logic [CODE_W-1:0] codes [NUM_CHANNELS];

   for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_channel
      channel_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_ch (
         .clk       (clk),
         .clr_int_n (clr_int_n),
         .wr_lo     (wr_en[PARTS_PER_CH*c]),
         .wr_hi     (wr_en[PARTS_PER_CH*c+1]),
         .xfer      (xfer),
         .data      (data_prev),
         .code      (codes[c])
      );
   end

   assign dac_a = codes[0];
   assign dac_b = codes[1];

   always @(posedge clk) begin
      if (!clr_int_n) begin
         AST_CLEAR_ZERO: assert (dac_a == '0 && dac_b == '0)
            else $error("codes not cleared"); // R6
      end
   end

   AST_PAIR_MOVES: assert property (@(posedge clk) disable iff (!clr_int_n)
      (!$stable(dac_a) || !$stable(dac_b)) |-> $past(xfer)) else $error("code changed outside update"); // R4
endmodule

// File: tb/tb_dual_dac_loader.sv
module tb_dual_dac_loader;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_data = '0;
   logic [1:0] bus_addr = '0;
   logic       cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1, clr_n = 1'b1;
   logic [11:0] dac_a, dac_b;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dual_dac_loader dut (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
      .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n), .clr_n(clr_n),
      .dac_a(dac_a), .dac_b(dac_b)
   );

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic cs_val);
      @(negedge clk);
      bus_addr = a; bus_data = d; cs_n = cs_val;
      idle(1);
      wr_n = 1'b0;
      idle(2);
      wr_n = 1'b1;
      idle(1);
      cs_n = 1'b1;
      bus_data = 8'h00;
      idle(4);
   endtask

   task automatic pulse_update();
      @(negedge clk);
      upd_n = 1'b0; wr_n = 1'b0;
      idle(2);
      upd_n = 1'b1; wr_n = 1'b1;
      idle(5);
   endtask

   task automatic t_reset();
      check("R9 reset dac_a", dac_a, 12'h000);
      check("R9 reset dac_b", dac_b, 12'h000);
   endtask

   task automatic t_load_and_update();
      bus_write(2'b00, 8'h5C, 1'b0);
      bus_write(2'b01, 8'hF3, 1'b0);   // upper nibble must be dropped (R1)
      bus_write(2'b10, 8'hA7, 1'b0);
      bus_write(2'b11, 8'h69, 1'b0);
      check("R8 dac_a before update", dac_a, 12'h000);
      check("R8 dac_b before update", dac_b, 12'h000);
      pulse_update();
      check("R1 R3 R4 dac_a after update", dac_a, 12'h35C);
      check("R1 R3 R4 dac_b after update", dac_b, 12'h9A7);
   endtask

   task automatic t_blocked_writes();
      bus_write(2'b00, 8'hFF, 1'b1);   // chip select high: R7
      @(negedge clk);
      bus_addr = 2'b10; bus_data = 8'h11; cs_n = 1'b0;  // no write pulse: R7
      idle(4);
      cs_n = 1'b1;
      pulse_update();
      check("R7 dac_a after blocked write", dac_a, 12'h35C);
      check("R7 dac_b after idle chip select", dac_b, 12'h9A7);
   endtask

   task automatic t_follow();
      @(negedge clk);
      upd_n = 1'b0;
      bus_write(2'b11, 8'h0E, 1'b0);
      check("R5 dac_b follows during update window", dac_b, 12'hEA7);
      bus_write(2'b00, 8'h21, 1'b0);
      check("R5 dac_a follows during update window", dac_a, 12'h321);
      upd_n = 1'b1;
      idle(4);
      bus_write(2'b01, 8'h07, 1'b0);
      check("R2 R8 write after window held off", dac_a, 12'h321);
      pulse_update();
      check("R2 R4 high nibble update", dac_a, 12'h721);
      check("R4 dac_b unchanged value reloaded", dac_b, 12'hEA7);
   endtask

   task automatic t_clear();
      @(negedge clk);
      clr_n = 1'b0;
      #1;
      check("R6 async clear dac_a", dac_a, 12'h000);
      check("R6 async clear dac_b", dac_b, 12'h000);
      bus_write(2'b10, 8'h44, 1'b0);   // ignored while clear low
      pulse_update();
      check("R6 update during clear", dac_b, 12'h000);
      clr_n = 1'b1;
      idle(4);
      pulse_update();
      check("R6 input regs cleared dac_a", dac_a, 12'h000);
      check("R6 input regs cleared dac_b", dac_b, 12'h000);
      bus_write(2'b10, 8'h3D, 1'b0);
      pulse_update();
      check("R2 write after clear release", dac_b, 12'h03D);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(4);
      t_reset();
      t_load_and_update();
      t_blocked_writes();
      t_follow();
      t_clear();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule